// File: doc/BRIEF.md
# Dual-Channel Response Capture Ring

This block listens to the command and response traffic of two serial sensor bus lanes and keeps a short history of selected responses. A lane that issues the analog-sample request command has the address of that command held back; the response that arrives with the lane's next completed transaction is then packed with that held address and a lane tag into one 16-bit word. Each lane owns a ring of four such words, so the newest captures overwrite the oldest.

A self-test loop mode changes the capture rule. A word is kept only when the returned data is uniform (all ones or all zeros) and matches the complement of the held address. The lane's ring pointer then steps on every transaction, so the ring stays aligned with the slot numbering of the host's main receive buffer.

A host pulls words out one per read request. The two rings are walked as one eight-slot cycle, lane 0 slots first, then lane 1 slots. Empty slots are passed over, and each word handed out is wiped. A request that finds nothing returns zero.

Top module: `resp_ring_capture`

## Requirements
- R1: A stored word is {held address [15:12], response data [11:2], lane tag [1:0]}. The tag is 2'b01 for lane 0 and 2'b10 for lane 1. Lane 0 owns combined slots 0..3 and lane 1 owns slots 4..7.
- R2: In normal mode, a completed transaction with command code 4'h2 holds its address. The lane's next completed transaction writes its response into the slot at that lane's write pointer, and the pointer then steps by one modulo 4, so a fifth capture overwrites the first. A transaction with any other command clears the held request.
- R3: If any bit of a transaction's error flags is set, the word is still written with its address and tag, but the data field [11:2] is zero.
- R4: In normal mode, a transaction with driver shutdown set writes nothing and leaves the write pointer unchanged.
- R5: In loop mode, a word is written only when a request is held, there is no shutdown and no error, the data is all ones or all zeros, and the held address equals the bitwise inverse of data[3:0]. The tag is the same as in normal mode.
- R6: In loop mode, the write pointer steps on every completed transaction, whether or not a word was written.
- R7: An abort on a lane drops that lane's held request and ignores a transaction that completes in the same cycle. It leaves that lane's stored words and write pointer unchanged.
- R8: A read request returns, on the next cycle on rd_data_o, the first non-zero slot found from the read pointer onward in combined cyclic order. That slot is cleared and the read pointer moves to the slot after it. rd_data_o holds its value between requests.
- R9: A read request while all eight slots are zero returns 16'h0000 and leaves the read pointer unchanged.
- R10: When a capture and a read clear hit the same slot in one cycle, the capture is kept and the read returns the old word.
- R11: After reset all slots are zero, all pointers are zero, no request is held, and rd_data_o is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 2 | Per-lane transaction-complete strobe |
| cmd_i | input | 2x4 | Per-lane command code of the completed transaction |
| addr_i | input | 2x4 | Per-lane address of the completed transaction |
| rsp_i | input | 2x10 | Per-lane response data of the completed transaction |
| err_i | input | 2x3 | Per-lane error status flags, zero means no error |
| shut_i | input | 2 | Per-lane driver shutdown seen during the transaction |
| abort_i | input | 2 | Per-lane abort strobe |
| loop_i | input | 2 | Per-lane loop (self-test) mode |
| rd_req_i | input | 1 | Read request, one word per cycle |
| rd_data_o | output | 16 | Word returned by the last read request |

## Verification
Every internal fault surfaces through the read port. A wrong write pointer, for example, puts a word in a slot that is popped in a different position of the combined order. The fault shows on the first read that reaches that slot, at most eight requests later. A stale held address or a missed clear shows up either as a wrong address field or as an extra non-zero word that a later read empties. The bench therefore drains the rings often and compares every returned word, including zero on an empty read, against its own model of slots and pointers.

// File: rtl/resp_ring_pkg.sv
package resp_ring_pkg;
    localparam int LANES   = 2;
    localparam int DEPTH   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 10;
    localparam int TAG_W   = 2;
    localparam int ERR_W   = 3;
    localparam int CMD_W   = 4;
    localparam int WORD_W  = ADDR_W + DATA_W + TAG_W;
    localparam int TOTAL   = LANES * DEPTH;
    localparam int LPTR_W  = $clog2(DEPTH);
    localparam int PTR_W   = $clog2(TOTAL);
    localparam logic [CMD_W-1:0] REQ_CMD = 4'h2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    function automatic logic [TAG_W-1:0] lane_tag(input int lane);
        return TAG_W'(lane + 1);
    endfunction

    function automatic logic is_uniform(input logic [DATA_W-1:0] d);
        return (d == '0) || (d == '1);
    endfunction
endpackage

// File: rtl/rrc_lane_capture.sv
module rrc_lane_capture
    import resp_ring_pkg::*;
#(
    parameter logic [TAG_W-1:0] TAG = 2'b01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] rsp_i,
    input  logic [ERR_W-1:0]  err_i,
    input  logic              shut_i,
    input  logic              abort_i,
    input  logic              loop_i,
    output logic              wr_en_o,
    output logic [LPTR_W-1:0] wr_idx_o,
    output entry_t            wr_word_o
);
    logic              pend_q;
    logic [ADDR_W-1:0] held_q;
    logic [LPTR_W-1:0] wptr_q;
    logic              act, clean, self_ok, take, adv;

    always_comb begin
        act     = done_i && !abort_i;
        clean   = (err_i == '0);
        self_ok = is_uniform(rsp_i) && (held_q == ~rsp_i[ADDR_W-1:0]);
        if (loop_i) begin
            take = act && pend_q && !shut_i && clean && self_ok;
            adv  = act;
        end else begin
            take = act && pend_q && !shut_i;
            adv  = take;
        end
    end

    assign wr_en_o   = take;
    assign wr_idx_o  = wptr_q;
    assign wr_word_o = '{addr: held_q, data: (clean ? rsp_i : '0), tag: TAG};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held_q <= '0;
            wptr_q <= '0;
        end else begin
            if (abort_i) begin
                pend_q <= 1'b0;
            end else if (done_i) begin
                pend_q <= (cmd_i == REQ_CMD);
                held_q <= addr_i;
            end
            if (adv) wptr_q <= wptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/rrc_ring_store.sv
module rrc_ring_store
    import resp_ring_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LANES-1:0]              wr_en_i,
    input  logic [LANES-1:0][LPTR_W-1:0]  wr_idx_i,
    input  entry_t [LANES-1:0]            wr_word_i,
    input  logic                          clr_en_i,
    input  logic [PTR_W-1:0]              clr_idx_i,
    output logic [TOTAL-1:0][WORD_W-1:0]  mem_o
);
    for (genvar e = 0; e < TOTAL; e++) begin : g_slot
        localparam int LN = e / DEPTH;
        localparam int SL = e % DEPTH;
        logic hit_wr, hit_clr;
        assign hit_wr  = wr_en_i[LN] && (wr_idx_i[LN] == LPTR_W'(SL));
        assign hit_clr = clr_en_i && (clr_idx_i == PTR_W'(e));
        always_ff @(posedge clk) begin
            if (rst)          mem_o[e] <= '0;
            else if (hit_wr)  mem_o[e] <= wr_word_i[LN];
            else if (hit_clr) mem_o[e] <= '0;
        end
    end
endmodule

// File: rtl/rrc_read_scan.sv
module rrc_read_scan
    import resp_ring_pkg::*;
(
    input  logic [TOTAL-1:0][WORD_W-1:0] mem_i,
    input  logic [PTR_W-1:0]             rptr_i,
    output logic                         found_o,
    output logic [PTR_W-1:0]             idx_o
);
    logic [PTR_W-1:0] cand;

    always_comb begin
        found_o = 1'b0;
        idx_o   = rptr_i;
        cand    = rptr_i;
        for (int k = TOTAL - 1; k >= 0; k--) begin
            cand = rptr_i + PTR_W'(k);
            if (mem_i[cand] != '0) begin
                found_o = 1'b1;
                idx_o   = cand;
            end
        end
    end
endmodule

// File: rtl/resp_ring_capture.sv
module resp_ring_capture
    import resp_ring_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0]             done_i,
    input  logic [LANES-1:0][CMD_W-1:0]  cmd_i,
    input  logic [LANES-1:0][ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0][DATA_W-1:0] rsp_i,
    input  logic [LANES-1:0][ERR_W-1:0]  err_i,
    input  logic [LANES-1:0]             shut_i,
    input  logic [LANES-1:0]             abort_i,
    input  logic [LANES-1:0]             loop_i,
    input  logic                         rd_req_i,
    output logic [WORD_W-1:0]            rd_data_o
);
    logic [LANES-1:0]              wr_en_w;
    logic [LANES-1:0][LPTR_W-1:0]  wr_idx_w;
    entry_t [LANES-1:0]            wr_word_w;
    logic [TOTAL-1:0][WORD_W-1:0]  mem_q;
    logic [PTR_W-1:0]              rptr_q;
    logic [PTR_W-1:0]              hit_idx;
    logic                          hit;
    logic                          clr_en;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rrc_lane_capture #(.TAG(lane_tag(l))) u_cap (
            .clk       (clk),
            .rst       (rst),
            .done_i    (done_i[l]),
            .cmd_i     (cmd_i[l]),
            .addr_i    (addr_i[l]),
            .rsp_i     (rsp_i[l]),
            .err_i     (err_i[l]),
            .shut_i    (shut_i[l]),
            .abort_i   (abort_i[l]),
            .loop_i    (loop_i[l]),
            .wr_en_o   (wr_en_w[l]),
            .wr_idx_o  (wr_idx_w[l]),
            .wr_word_o (wr_word_w[l])
        );
    end

    rrc_read_scan u_scan (
        .mem_i   (mem_q),
        .rptr_i  (rptr_q),
        .found_o (hit),
        .idx_o   (hit_idx)
    );

    assign clr_en = rd_req_i && hit;

    rrc_ring_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_w),
        .wr_idx_i  (wr_idx_w),
        .wr_word_i (wr_word_w),
        .clr_en_i  (clr_en),
        .clr_idx_i (hit_idx),
        .mem_o     (mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q    <= '0;
            rd_data_o <= '0;
        end else if (rd_req_i) begin
            rd_data_o <= hit ? mem_q[hit_idx] : '0;
            if (hit) rptr_q <= hit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/resp_ring_checker.sv
module resp_ring_checker
    import resp_ring_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [LANES-1:0]             done_i,
    input logic [LANES-1:0]             shut_i,
    input logic [LANES-1:0]             abort_i,
    input logic [LANES-1:0]             loop_i,
    input logic                         rd_req_i,
    input logic [WORD_W-1:0]            rd_data_o,
    input logic [TOTAL-1:0][WORD_W-1:0] mem_q,
    input logic [PTR_W-1:0]             rptr_q,
    input logic [LANES-1:0][LPTR_W-1:0] wr_idx_w
);
    for (genvar e = 0; e < TOTAL; e++) begin : g_tag
        p_slot_tag_r1: assert property (@(posedge clk) disable iff (rst)
            (mem_q[e] != '0) |-> (mem_q[e][TAG_W-1:0] == lane_tag(e / DEPTH)));
    end

    p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && mem_q == '0) |=> (rd_data_o == '0 && $stable(rptr_q)));

    p_pop_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && mem_q != '0) |=> (rd_data_o != '0));

    for (genvar l = 0; l < LANES; l++) begin : g_ln
        p_shut_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (done_i[l] && shut_i[l] && !loop_i[l]) |=> $stable(wr_idx_w[l]));

        p_loop_step_r6: assert property (@(posedge clk) disable iff (rst)
            (done_i[l] && loop_i[l] && !abort_i[l])
                |=> (wr_idx_w[l] == LPTR_W'($past(wr_idx_w[l]) + 1'b1)));

        p_abort_keep_r7: assert property (@(posedge clk) disable iff (rst)
            abort_i[l] |=> $stable(wr_idx_w[l]));
    end
endmodule

bind resp_ring_capture resp_ring_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .done_i    (done_i),
    .shut_i    (shut_i),
    .abort_i   (abort_i),
    .loop_i    (loop_i),
    .rd_req_i  (rd_req_i),
    .rd_data_o (rd_data_o),
    .mem_q     (mem_q),
    .rptr_q    (rptr_q),
    .wr_idx_w  (wr_idx_w)
);

// File: tb/resp_ring_capture_test.sv
module resp_ring_capture_test;
    import resp_ring_pkg::*;

    localparam time CLK_P = 4ns;

    logic                         clk = 1'b0;
    logic                         rst;
    logic [LANES-1:0]             done_i;
    logic [LANES-1:0][CMD_W-1:0]  cmd_i;
    logic [LANES-1:0][ADDR_W-1:0] addr_i;
    logic [LANES-1:0][DATA_W-1:0] rsp_i;
    logic [LANES-1:0][ERR_W-1:0]  err_i;
    logic [LANES-1:0]             shut_i;
    logic [LANES-1:0]             abort_i;
    logic [LANES-1:0]             loop_i;
    logic                         rd_req_i;
    logic [WORD_W-1:0]            rd_data_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [WORD_W-1:0] m_mem [TOTAL];
    bit                m_pend [LANES];
    logic [ADDR_W-1:0] m_held [LANES];
    int                m_wptr [LANES];
    int                m_rptr;
    logic [WORD_W-1:0] m_rd;

    resp_ring_capture uut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit uni(input logic [DATA_W-1:0] d);
        return (d == '0) || (d == '1);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < TOTAL; i++) m_mem[i] = '0;
        for (int l = 0; l < LANES; l++) begin
            m_pend[l] = 0; m_held[l] = '0; m_wptr[l] = 0;
        end
        m_rptr = 0; m_rd = '0;
    endtask

    task automatic model_edge();
        bit found = 0;
        int idx = 0;
        for (int k = 0; k < TOTAL; k++) begin
            int j = (m_rptr + k) % TOTAL;
            if (!found && m_mem[j] != '0) begin found = 1; idx = j; end
        end
        if (rd_req_i) begin
            m_rd = found ? m_mem[idx] : '0;
            if (found) begin m_mem[idx] = '0; m_rptr = (idx + 1) % TOTAL; end
        end
        for (int l = 0; l < LANES; l++) begin
            bit act = done_i[l] && !abort_i[l];
            bit ok  = (err_i[l] == '0);
            bit take, adv;
            if (loop_i[l]) begin
                take = act && m_pend[l] && !shut_i[l] && ok && uni(rsp_i[l])
                       && (m_held[l] == ~rsp_i[l][ADDR_W-1:0]);
                adv = act;
            end else begin
                take = act && m_pend[l] && !shut_i[l];
                adv = take;
            end
            if (take)
                m_mem[l*DEPTH + m_wptr[l]] = {m_held[l], (ok ? rsp_i[l] : 10'h0),
                                              2'(l + 1)};
            if (adv) m_wptr[l] = (m_wptr[l] + 1) % DEPTH;
            if (abort_i[l]) m_pend[l] = 0;
            else if (done_i[l]) begin
                m_pend[l] = (cmd_i[l] == 4'h2);
                m_held[l] = addr_i[l];
            end
        end
    endtask

    task automatic idle();
        done_i = '0; abort_i = '0; shut_i = '0; err_i = '0; rd_req_i = 1'b0;
    endtask

    task automatic cyc(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(rd_data_o, m_rd, req);
        idle();
    endtask

    task automatic txn(input int l, input logic [3:0] c, input logic [3:0] a,
                       input logic [9:0] d, input string req);
        done_i[l] = 1'b1; cmd_i[l] = c; addr_i[l] = a; rsp_i[l] = d;
        cyc(req);
    endtask

    task automatic rd(input string req);
        rd_req_i = 1'b1;
        cyc(req);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd4242);
        rst = 1'b1; idle(); cmd_i = '0; addr_i = '0; rsp_i = '0; loop_i = '0;
        model_reset();
        repeat (3) @(negedge clk);
        check(rd_data_o, 16'h0000, "R11 reset output");
        rst = 1'b0;
        rd("R11 empty after reset");
        rd("R9 empty read");
        check(rd_data_o, 16'h0000, "R9 empty returns zero");

        // R1 / R2: request then response on lane 0
        txn(0, 4'h2, 4'h5, 10'h000, "R2 request");
        txn(0, 4'h0, 4'h0, 10'h155, "R2 response");
        rd("R1 pack");
        check(rd_data_o, 16'h5555, "R1 word layout lane0");

        // R3: error zeroes data, keeps address and tag
        txn(1, 4'h2, 4'hA, 10'h000, "R3 request");
        err_i[1] = 3'b010;
        txn(1, 4'h0, 4'h0, 10'h3FF, "R3 response with error");
        rd("R3 pop");
        check(rd_data_o, 16'hA002, "R3 error word");

        // R4: shutdown suppresses the write
        txn(0, 4'h2, 4'h3, 10'h000, "R4 request");
        shut_i[0] = 1'b1;
        txn(0, 4'h0, 4'h0, 10'h001, "R4 shutdown txn");
        rd("R4 nothing stored");
        check(rd_data_o, 16'h0000, "R4 empty after shutdown");

        // R5 / R6: loop mode on lane 1
        loop_i[1] = 1'b1;
        txn(1, 4'h2, 4'h0, 10'h000, "R6 loop request");
        txn(1, 4'h2, 4'h1, 10'h3FF, "R5 loop match");
        txn(1, 4'h0, 4'h0, 10'h3FF, "R5 loop mismatch");
        rd("R5 loop pop");
        check(rd_data_o, 16'h0FFE, "R5 loop word");
        rd("R6 loop only one word");
        loop_i[1] = 1'b0;

        // R7: abort drops the held request
        txn(0, 4'h2, 4'h7, 10'h000, "R7 request");
        abort_i[0] = 1'b1;
        txn(0, 4'h0, 4'h0, 10'h005, "R7 abort with done");
        txn(0, 4'h0, 4'h0, 10'h005, "R7 after abort");
        rd("R7 nothing stored");
        check(rd_data_o, 16'h0000, "R7 empty after abort");

        // R2 overwrite and R8 combined order
        for (int i = 0; i < 6; i++) txn(0, 4'h2, 4'(i + 1), 10'(i * 7 + 1), "R2 fill lane0");
        for (int i = 0; i < 3; i++) txn(1, 4'h2, 4'(i + 8), 10'(i * 5 + 2), "R2 fill lane1");
        for (int i = 0; i < 9; i++) rd("R8 drain order");

        // R10: capture and clear on the same slot
        for (int i = 0; i < 5; i++) txn(0, 4'h2, 4'(i + 3), 10'(i + 40), "R10 fill");
        done_i[0] = 1'b1; cmd_i[0] = 4'h2; addr_i[0] = 4'hC; rsp_i[0] = 10'h2AA;
        rd_req_i = 1'b1;
        cyc("R10 simultaneous");
        for (int i = 0; i < 6; i++) rd("R10 drain");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            for (int l = 0; l < LANES; l++) begin
                done_i[l]  = ($urandom % 3) == 0;
                cmd_i[l]   = ($urandom % 2) ? 4'h2 : 4'($urandom % 16);
                addr_i[l]  = 4'($urandom);
                rsp_i[l]   = ($urandom % 4 == 0) ? (($urandom % 2) ? 10'h3FF : 10'h000)
                                                 : 10'($urandom);
                if ($urandom % 4 == 0) addr_i[l] = ($urandom % 2) ? 4'h0 : 4'hF;
                err_i[l]   = ($urandom % 8 == 0) ? 3'($urandom) : 3'b000;
                shut_i[l]  = ($urandom % 10) == 0;
                abort_i[l] = ($urandom % 16) == 0;
                if (n % 500 == 0) loop_i[l] = $urandom % 2;
            end
            rd_req_i = ($urandom % 3) == 0;
            cyc("R2 R8 random");
        end
        for (int i = 0; i < 9; i++) rd("R8 final drain");
        rd("R9 final empty");
        check(rd_data_o, 16'h0000, "R9 final empty zero");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule